// File: doc/BRIEF.md
# Slow-Rate Infrared Receive Deframer

This block sits between a slow-rate infrared UART receiver and the receive FIFO. It takes the raw byte stream and removes the framing around each link-layer packet. Begin flags (0xC0) open a frame, and any extra begin flags that come before the first data byte are dropped. An end flag (0xC1) closes the frame. An escape byte (0x7D) is removed, and the byte after it is restored by an XOR with 0x20. Only the payload reaches the output, and the two trailing FCS bytes stay in place because the block does not check the CRC.

Each output byte comes with a valid strobe. The close of a frame is marked by a single-cycle strobe, and two error flags are valid in that same cycle. One flag reports a frame that was reopened before it was ever closed. The other reports a frame longer than a programmable 12-bit limit. A live count of the bytes passed in the current frame can be read at all times. It clears when a new frame opens and holds its value after the frame closes. The two flag values are available as a constant 16-bit word.

The filter works only when it is enabled and the link is in slow-rate mode, or when a test bit allows it in other modes. When the filter is not working, bytes pass through untouched.

Top module: `sir_rx_deframer`

## Requirements
- R1: `flag_word` reads 16'hC1C0: the begin flag in bits [7:0] and the end flag in bits [15:8].
- R2: A non-flag, non-escape byte received inside an open frame appears on `out_byte` with `out_valid` high one clock after it is accepted. Cycles with `in_valid` low produce no output.
- R3: Inside a frame, an escape byte 0x7D produces no output, and the next data byte is output XORed with 0x20. This applies even when that next byte is 0x7D. An end flag that follows an escape still closes the frame.
- R4: Begin flags 0xC0 that arrive while the frame has no data byte yet are dropped silently: no output, no frame-end strobe, no error.
- R5: A begin flag that arrives while a frame holding at least one data byte is still open raises `frame_end` and `err_no_eof` one clock later, and a new frame starts.
- R6: An end flag 0xC1 inside an open frame raises `frame_end` for one clock, one clock later. An end flag with no open frame is ignored.
- R7: Bytes received while no frame is open produce no output and leave `byte_cnt` unchanged. Flag bytes are never output while the filter is working.
- R8: `byte_cnt` increments by one for each byte output inside a frame, clears to 0 when a begin flag is accepted, and holds after the frame closes.
- R9: `err_len` is raised together with `frame_end` when the frame's byte count exceeds `max_len[11:0]`. A count equal to the limit gives no error.
- R10: `byte_cnt` saturates at 4095. A frame that delivers more than 4095 bytes raises `err_len` at its close even when `max_len` is 4095.
- R11: The filter works only when `filt_en` is high and either `sir_mode` or `filt_test` is high. Otherwise each valid byte passes through one clock later, with no frame-end strobe and with `byte_cnt` held.
- R12: While `rst_n` is low, all outputs except `flag_word` are 0 and no frame is open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| filt_en | input | 1 | Filter enable |
| sir_mode | input | 1 | Link is in slow-rate mode |
| filt_test | input | 1 | Allows the filter outside slow-rate mode |
| max_len | input | 12 | Maximum frame length in bytes |
| in_valid | input | 1 | Input byte strobe |
| in_byte | input | 8 | Received byte |
| out_valid | output | 1 | Output byte strobe |
| out_byte | output | 8 | Unwrapped byte |
| frame_end | output | 1 | One-cycle frame close strobe |
| err_no_eof | output | 1 | Frame reopened without an end flag (valid with frame_end) |
| err_len | output | 1 | Frame exceeded the length limit (valid with frame_end) |
| byte_cnt | output | 12 | Bytes passed in the current frame |
| flag_word | output | 16 | Constant begin/end flag values |

## Verification
The assertions run on every cycle and check the following:
- Every output strobe traces back to an accepted byte.
- Flag bytes never leak to the output while the filter is working.
- Both error flags appear only with `frame_end`, and `frame_end` follows only a flag byte.
- The counter only steps by one or clears.
- Bytes pass through unchanged when the filter is inactive.

Only the bench scenarios can show the following:
- The exact de-escaped values, including a doubled escape.
- The silent dropping of repeated begin flags.
- The boundary between a count equal to the limit and one above it.
- Saturation at 4095 and the overflow error it produces.
- The handling of a stray end flag.

// File: rtl/sir_rx_deframer.sv
module sir_rx_deframer #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          filt_en,
  input  logic          sir_mode,
  input  logic          filt_test,
  input  logic [CW-1:0] max_len,
  input  logic          in_valid,
  input  logic [7:0]    in_byte,
  output logic          out_valid,
  output logic [7:0]    out_byte,
  output logic          frame_end,
  output logic          err_no_eof,
  output logic          err_len,
  output logic [CW-1:0] byte_cnt,
  output logic [15:0]   flag_word
);
  localparam logic [7:0]    BOF   = 8'hC0;
  localparam logic [7:0]    EOF   = 8'hC1;
  localparam logic [7:0]    ESC   = 8'h7D;
  localparam logic [7:0]    XMASK = 8'h20;
  localparam logic [CW-1:0] CMAX  = {CW{1'b1}};

  logic in_frame, esc, ovf;

  wire active = filt_en & (sir_mode | filt_test);
  wire is_bof = (in_byte == BOF);
  wire is_eof = (in_byte == EOF);
  wire is_esc = (in_byte == ESC);
  wire over   = (byte_cnt > max_len) | ovf;

  assign flag_word = {EOF, BOF};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_byte   <= '0;
      frame_end  <= 1'b0;
      err_no_eof <= 1'b0;
      err_len    <= 1'b0;
      byte_cnt   <= '0;
      in_frame   <= 1'b0;
      esc        <= 1'b0;
      ovf        <= 1'b0;
    end else begin
      out_valid  <= 1'b0;
      frame_end  <= 1'b0;
      err_no_eof <= 1'b0;
      err_len    <= 1'b0;
      if (!active) begin
        in_frame <= 1'b0;
        esc      <= 1'b0;
        if (in_valid) begin
          out_valid <= 1'b1;
          out_byte  <= in_byte;
        end
      end else if (in_valid) begin
        if (is_bof) begin
          if (in_frame && byte_cnt != '0) begin
            frame_end  <= 1'b1;
            err_no_eof <= 1'b1;
            err_len    <= over;
          end
          in_frame <= 1'b1;
          esc      <= 1'b0;
          byte_cnt <= '0;
          ovf      <= 1'b0;
        end else if (is_eof) begin
          if (in_frame) begin
            frame_end <= 1'b1;
            err_len   <= over;
          end
          in_frame <= 1'b0;
          esc      <= 1'b0;
        end else if (in_frame) begin
          if (is_esc && !esc) begin
            esc <= 1'b1;
          end else begin
            out_valid <= 1'b1;
            out_byte  <= in_byte ^ (esc ? XMASK : 8'h00);
            esc       <= 1'b0;
            if (byte_cnt == CMAX) ovf <= 1'b1;
            else                  byte_cnt <= byte_cnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sir_rx_deframer_chk.sv
module sir_rx_deframer_chk #(
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          filt_en,
  input logic          sir_mode,
  input logic          filt_test,
  input logic [CW-1:0] max_len,
  input logic          in_valid,
  input logic [7:0]    in_byte,
  input logic          out_valid,
  input logic [7:0]    out_byte,
  input logic          frame_end,
  input logic          err_no_eof,
  input logic          err_len,
  input logic [CW-1:0] byte_cnt,
  input logic [15:0]   flag_word
);
  wire act  = filt_en & (sir_mode | filt_test);
  wire flag = (in_byte == 8'hC0) | (in_byte == 8'hC1);

  // R2
  out_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  // R11
  pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!act && in_valid) |=> (out_valid && out_byte == $past(in_byte) && !frame_end));

  // R7
  flag_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && in_valid && flag) |=> !out_valid);

  // R5
  err_tie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_no_eof || err_len) |-> frame_end);

  // R6
  end_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> $past(in_valid && act && flag));

  // R8
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_cnt != $past(byte_cnt)) |-> (byte_cnt == '0 || byte_cnt == CW'($past(byte_cnt) + 1'b1)));
endmodule

bind sir_rx_deframer sir_rx_deframer_chk #(.CW(CW)) u_chk (.*);

// File: tb/sim_sir_rx_deframer.sv
module sim_sir_rx_deframer;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        filt_en = 1'b1, sir_mode = 1'b1, filt_test = 1'b0;
  logic [11:0] max_len = 12'd5;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        out_valid, frame_end, err_no_eof, err_len;
  logic [7:0]  out_byte;
  logic [11:0] byte_cnt;
  logic [15:0] flag_word;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sir_rx_deframer u0 (
    .clk(clk), .rst_n(rst_n), .filt_en(filt_en), .sir_mode(sir_mode),
    .filt_test(filt_test), .max_len(max_len), .in_valid(in_valid),
    .in_byte(in_byte), .out_valid(out_valid), .out_byte(out_byte),
    .frame_end(frame_end), .err_no_eof(err_no_eof), .err_len(err_len),
    .byte_cnt(byte_cnt), .flag_word(flag_word)
  );

  // {req, in_valid, in_byte, out_valid, out_byte, fe, no_eof, len, cnt}
  localparam logic [36:0] VEC [NV] = '{
    {4'd6, 1'b1, 8'hC1, 1'b0, 8'h00, 3'b000, 12'd0},  // R6 stray end flag
    {4'd7, 1'b1, 8'h41, 1'b0, 8'h00, 3'b000, 12'd0},  // R7 outside frame
    {4'd4, 1'b1, 8'hC0, 1'b0, 8'h00, 3'b000, 12'd0},  // R4
    {4'd4, 1'b1, 8'hC0, 1'b0, 8'h00, 3'b000, 12'd0},
    {4'd4, 1'b1, 8'hC0, 1'b0, 8'h00, 3'b000, 12'd0},
    {4'd2, 1'b1, 8'h11, 1'b1, 8'h11, 3'b000, 12'd1},  // R2
    {4'd2, 1'b0, 8'h55, 1'b0, 8'h00, 3'b000, 12'd1},
    {4'd3, 1'b1, 8'h7D, 1'b0, 8'h00, 3'b000, 12'd1},  // R3
    {4'd3, 1'b1, 8'h5E, 1'b1, 8'h7E, 3'b000, 12'd2},
    {4'd3, 1'b1, 8'h7D, 1'b0, 8'h00, 3'b000, 12'd2},
    {4'd3, 1'b1, 8'h7D, 1'b1, 8'h5D, 3'b000, 12'd3},
    {4'd8, 1'b1, 8'h22, 1'b1, 8'h22, 3'b000, 12'd4},  // R8
    {4'd6, 1'b1, 8'hC1, 1'b0, 8'h00, 3'b100, 12'd4},
    {4'd7, 1'b1, 8'h33, 1'b0, 8'h00, 3'b000, 12'd4},
    {4'd8, 1'b1, 8'hC0, 1'b0, 8'h00, 3'b000, 12'd0},
    {4'd8, 1'b1, 8'h01, 1'b1, 8'h01, 3'b000, 12'd1},
    {4'd8, 1'b1, 8'h02, 1'b1, 8'h02, 3'b000, 12'd2},
    {4'd8, 1'b1, 8'h03, 1'b1, 8'h03, 3'b000, 12'd3},
    {4'd8, 1'b1, 8'h04, 1'b1, 8'h04, 3'b000, 12'd4},
    {4'd8, 1'b1, 8'h05, 1'b1, 8'h05, 3'b000, 12'd5},
    {4'd8, 1'b1, 8'h06, 1'b1, 8'h06, 3'b000, 12'd6},
    {4'd5, 1'b1, 8'hC0, 1'b0, 8'h00, 3'b111, 12'd0},  // R5 with R9 (6 > 5)
    {4'd9, 1'b1, 8'h0A, 1'b1, 8'h0A, 3'b000, 12'd1},
    {4'd9, 1'b1, 8'h0A, 1'b1, 8'h0A, 3'b000, 12'd2},
    {4'd9, 1'b1, 8'h0A, 1'b1, 8'h0A, 3'b000, 12'd3},
    {4'd9, 1'b1, 8'h0A, 1'b1, 8'h0A, 3'b000, 12'd4},
    {4'd9, 1'b1, 8'h0A, 1'b1, 8'h0A, 3'b000, 12'd5},
    {4'd9, 1'b1, 8'hC1, 1'b0, 8'h00, 3'b100, 12'd5},  // R9 equal: no error
    {4'd4, 1'b1, 8'hC0, 1'b0, 8'h00, 3'b000, 12'd0},
    {4'd3, 1'b1, 8'h7D, 1'b0, 8'h00, 3'b000, 12'd0},
    {4'd6, 1'b1, 8'hC1, 1'b0, 8'h00, 3'b100, 12'd0},  // R3 end after escape
    {4'd6, 1'b1, 8'hC1, 1'b0, 8'h00, 3'b000, 12'd0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic v, input logic [7:0] b);
    in_valid = v;
    in_byte  = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 out_valid", 32'(out_valid), 0);
    chk("R12 frame_end", 32'(frame_end), 0);
    chk("R12 errs", 32'({err_no_eof, err_len}), 0);
    chk("R12 byte_cnt", 32'(byte_cnt), 0);
    // R1
    chk("R1 flag_word", 32'(flag_word), 32'hC1C0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [36:0] v;
      string tag;
      v = VEC[i];
      send(v[32], v[31:24]);
      tag = $sformatf("R%0d vec%0d", v[36:33], i);
      chk({tag, " out_valid"}, 32'(out_valid), 32'(v[23]));
      if (v[23]) chk({tag, " out_byte"}, 32'(out_byte), 32'(v[22:15]));
      chk({tag, " fe/noeof/len"}, 32'({frame_end, err_no_eof, err_len}), 32'(v[14:12]));
      chk({tag, " byte_cnt"}, 32'(byte_cnt), 32'(v[11:0]));
    end

    // R11 filter blocked outside slow-rate mode without test bit
    sir_mode = 1'b0;
    send(1'b1, 8'hC0);
    chk("R11 pass valid", 32'(out_valid), 1);
    chk("R11 pass byte", 32'(out_byte), 32'hC0);
    chk("R11 no frame_end", 32'(frame_end), 0);
    chk("R11 cnt held", 32'(byte_cnt), 0);
    filt_test = 1'b1;
    send(1'b1, 8'hC0);
    chk("R11 test allows filter", 32'(out_valid), 0);
    send(1'b1, 8'h41);
    send(1'b1, 8'hC1);
    chk("R11 test frame_end", 32'(frame_end), 1);
    chk("R11 test cnt", 32'(byte_cnt), 1);
    filt_test = 1'b0;
    sir_mode = 1'b1;
    filt_en = 1'b0;
    send(1'b1, 8'h7D);
    chk("R11 disabled pass", 32'({out_valid, out_byte}), 32'h17D);
    chk("R11 disabled cnt held", 32'(byte_cnt), 1);
    filt_en = 1'b1;

    // R10 saturation
    max_len = 12'hFFF;
    send(1'b1, 8'hC0);
    for (int k = 0; k < 4100; k++) send(1'b1, 8'h55);
    chk("R10 cnt saturated", 32'(byte_cnt), 4095);
    send(1'b1, 8'hC1);
    chk("R10 frame_end", 32'(frame_end), 1);
    chk("R10 err_len", 32'(err_len), 1);
    send(1'b1, 8'hC0);
    send(1'b1, 8'h01);
    send(1'b1, 8'hC1);
    chk("R10 overflow cleared", 32'({frame_end, err_len}), 32'b10);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule